// File: doc/BRIEF.md
# Serial Two-Operand Adder

This block takes two 4-bit unsigned numbers over one serial data wire and returns their sum. A bit is taken on each clock edge at which the valid strobe is high. The first four bits taken make up operand A and the following four make up operand B. Each operand is sent most significant bit first. Cycles with the strobe low are ignored, so a sender may leave gaps anywhere in the stream.

The control is a two-state machine. State `ST_LOAD_A` routes accepted bits into the A shift register. Transition `A_TO_B` is taken on the fourth accepted bit, which enters state `ST_LOAD_B`. That state routes bits into the B shift register. Transition `B_TO_A` is taken on the eighth accepted bit and returns to `ST_LOAD_A`. On that transition a ripple chain of full adders sums A and the updated B, and the result is registered. The done flag is raised for one cycle. The receive counter returns to zero, so the next pair can begin with the very next strobe.

The registered sum and carry keep their values until the next pair completes. A synchronous reset discards any partly received pair.

Top module: `serial_pair_adder`

## Requirements
- R1: While `rst` is high at a clock edge, the design returns to `ST_LOAD_A` with a zero bit count. After that edge, `sum`, `carry` and `done` read 0.
- R2: The first four accepted bits form A, MSB first. The first accepted bit is A[3] and the fourth is A[0].
- R3: Accepted bits five to eight form B, MSB first. The fifth accepted bit is B[3] and the eighth is B[0].
- R4: A bit is accepted only on an edge at which `svalid` is 1. Edges with `svalid` at 0 change neither the bit count nor any stored bit, whatever `sdata` holds.
- R5: `done` is 1 for exactly the one cycle that follows the edge accepting the eighth bit, and is 0 at all other times.
- R6: When `done` rises, `sum` equals (A+B) mod 16 and `carry` equals bit 4 of A+B. For example, 15+15 gives sum 4'b1110 and carry 1.
- R7: `sum` and `carry` keep their values from one completion to the next, including through idle cycles.
- R8: After the eighth bit, the next accepted bit is A[3] of a new pair. Pairs may follow one another with no idle cycle between them.
- R9: A reset in the middle of a pair discards the bits already taken. The next accepted bit is treated as A[3].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdata | input | 1 | Serial operand bit |
| svalid | input | 1 | High when `sdata` carries a bit to accept |
| sum | output | 4 | Registered low four bits of A+B |
| carry | output | 1 | Registered carry-out of A+B |
| done | output | 1 | One-cycle pulse when a new sum is presented |

## Verification
Suppose the bit counter or the state slips by one position, or counts an idle cycle. Then `done` fires one accepted bit early or late, and that is visible in the very cycle the bench expects the pulse. A misrouted or misordered bit changes an operand's weight. For example, A=1 would read as 8, which shows in `sum` at the pulse of the same pair. Stale partial bits left by a mid-pair reset would corrupt the first sum after the reset.

// File: rtl/spa_pkg.sv
package spa_pkg;
    typedef enum logic [0:0] {
        ST_LOAD_A = 1'b0,
        ST_LOAD_B = 1'b1
    } spa_state_t;
endpackage

// File: rtl/spa_ctrl.sv
module spa_ctrl
    import spa_pkg::*;
#(
    parameter int NBITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_ok,
    output logic shift_a,
    output logic shift_b,
    output logic last_bit
);
    localparam int TOTAL = 2 * NBITS;
    localparam int CW    = $clog2(TOTAL);

    spa_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          a_full;

    assign a_full   = (cnt_q == CW'(NBITS - 1));
    assign shift_a  = bit_ok && (state_q == ST_LOAD_A);
    assign shift_b  = bit_ok && (state_q == ST_LOAD_B);
    assign last_bit = shift_b && (cnt_q == CW'(TOTAL - 1));

    // next-state: A_TO_B on the last A bit, B_TO_A on the last B bit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD_A: if (a_full)   state_d = ST_LOAD_B;
            ST_LOAD_B: if (last_bit) state_d = ST_LOAD_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD_A;
            cnt_q   <= '0;
        end else if (bit_ok) begin
            state_q <= state_d;
            cnt_q   <= last_bit ? '0 : cnt_q + 1'b1;
        end
    end

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !bit_ok |=> ($stable(cnt_q) && $stable(state_q)));

    assert_b_phase_count_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD_B) |-> (cnt_q >= CW'(NBITS)));

    assert_wrap_to_a_R8: assert property (@(posedge clk) disable iff (rst)
        last_bit |=> (state_q == ST_LOAD_A && cnt_q == '0));
endmodule

// File: rtl/spa_shreg.sv
module spa_shreg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q,
    output logic [W-1:0] q_nxt
);
    assign q_nxt = {q[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= q_nxt;
    end

    assert_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
        en |=> (q[0] == $past(din)));

    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));
endmodule

// File: rtl/spa_rca.sv
module spa_rca #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s,
    output logic         cout
);
    logic [W:0] c;
    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign s[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign cout = c[W];
endmodule

// File: rtl/serial_pair_adder.sv
module serial_pair_adder #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sdata,
    input  logic         svalid,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         done
);
    logic         shift_a, shift_b, last_bit;
    logic [W-1:0] a_q, a_nxt, b_q, b_nxt;
    logic [W-1:0] add_s;
    logic         add_c;

    spa_ctrl #(.NBITS(W)) u_ctrl (
        .clk(clk), .rst(rst), .bit_ok(svalid),
        .shift_a(shift_a), .shift_b(shift_b), .last_bit(last_bit)
    );

    spa_shreg #(.W(W)) u_reg_a (
        .clk(clk), .rst(rst), .en(shift_a), .din(sdata),
        .q(a_q), .q_nxt(a_nxt)
    );

    spa_shreg #(.W(W)) u_reg_b (
        .clk(clk), .rst(rst), .en(shift_b), .din(sdata),
        .q(b_q), .q_nxt(b_nxt)
    );

    // B's final bit is folded in through b_nxt so the sum lands with it
    spa_rca #(.W(W)) u_add (
        .a(a_q), .b(b_nxt), .s(add_s), .cout(add_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum   <= '0;
            carry <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= last_bit;
            if (last_bit) begin
                sum   <= add_s;
                carry <= add_c;
            end
        end
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_cause_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(svalid));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({carry, sum}));

    assert_no_shift_both_R3: assert property (@(posedge clk) disable iff (rst)
        !(shift_a && shift_b));

    wire unused_ok = ^{a_nxt, b_q};
endmodule

// File: tb/sim_serial_pair_adder.sv
`timescale 1ns/1ps
module sim_serial_pair_adder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sdata = 1'b0;
    logic       svalid = 1'b0;
    logic [3:0] sum;
    logic       carry, done;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    serial_pair_adder u0 (
        .clk(clk), .rst(rst), .sdata(sdata), .svalid(svalid),
        .sum(sum), .carry(carry), .done(done)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            svalid = 1'b0;
            sdata  = i[0];
            @(negedge clk);
        end
    endtask

    task automatic send_bit(input logic b);
        sdata  = b;
        svalid = 1'b1;
        @(negedge clk);
        svalid = 1'b0;
    endtask

    // gap: idle cycles inserted after each bit
    task automatic send_pair(input logic [3:0] a, input logic [3:0] b, input int gap);
        for (int i = 3; i >= 0; i--) begin
            send_bit(a[i]);
            if (done) check(1'b0, "R5 early done", 1, 0);
            idle(gap);
        end
        for (int i = 3; i >= 0; i--) begin
            send_bit(b[i]);
            if (i > 0) begin
                if (done) check(1'b0, "R5 early done", 1, 0);
                idle(gap);
            end
        end
    endtask

    task automatic expect_result(input logic [3:0] a, input logic [3:0] b, input string tag);
        logic [4:0] e;
        e = {1'b0, a} + {1'b0, b};
        check(done === 1'b1, {tag, " R5 done"}, int'(done), 1);
        check({carry, sum} === e, {tag, " R6 result"}, int'({carry, sum}), int'(e));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(sum === 4'd0, "R1 sum", int'(sum), 0);
        check(carry === 1'b0, "R1 carry", int'(carry), 0);
        check(done === 1'b0, "R1 done", int'(done), 0);
    endtask

    task automatic t_order();
        send_pair(4'd1, 4'd0, 0);
        expect_result(4'd1, 4'd0, "R2 A msb-first");
        idle(1);
        check(done === 1'b0, "R5 pulse width", int'(done), 0);
        send_pair(4'd0, 4'd4, 0);
        expect_result(4'd0, 4'd4, "R3 B msb-first");
        idle(1);
        send_pair(4'd3, 4'd5, 0);
        expect_result(4'd3, 4'd5, "R6 basic");
        idle(1);
    endtask

    task automatic t_max();
        send_pair(4'd15, 4'd15, 0);
        expect_result(4'd15, 4'd15, "R6 max");
        idle(1);
        send_pair(4'd0, 4'd0, 0);
        expect_result(4'd0, 4'd0, "R6 zero");
        idle(1);
    endtask

    task automatic t_gaps();
        send_pair(4'd9, 4'd6, 3);
        expect_result(4'd9, 4'd6, "R4 gaps");
        idle(1);
    endtask

    task automatic t_hold();
        send_pair(4'd12, 4'd7, 0);
        expect_result(4'd12, 4'd7, "R7 setup");
        idle(6);
        check({carry, sum} === 5'd19, "R7 hold", int'({carry, sum}), 19);
        check(done === 1'b0, "R7 done low", int'(done), 0);
        send_bit(1'b1);
        idle(2);
        check({carry, sum} === 5'd19, "R7 hold partial", int'({carry, sum}), 19);
        do_reset();
    endtask

    task automatic t_back_to_back();
        send_pair(4'd10, 4'd3, 0);
        expect_result(4'd10, 4'd3, "R8 first");
        send_pair(4'd2, 4'd14, 0);
        expect_result(4'd2, 4'd14, "R8 second");
        idle(1);
    endtask

    task automatic t_mid_reset();
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b1);
        do_reset();
        check({carry, sum} === 5'd0, "R9 cleared", int'({carry, sum}), 0);
        send_pair(4'd2, 4'd3, 1);
        expect_result(4'd2, 4'd3, "R9 after reset");
        idle(1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_order();
        t_max();
        t_gaps();
        t_hold();
        t_back_to_back();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule